// File: doc/BRIEF.md
# Guarded System Configuration Register Bank

This block holds five 8-bit system configuration registers behind a simple CPU-side register bus. A write is one cycle with `wr_en` high, an offset on `addr` and a byte on `wdata`. Reads need no strobe: `rdata` always shows the register selected by `addr`. The block does no bus decoding beyond its five offsets and models only the stored bits.

In normal operation each bit has its own write rule. Some bits accept writes at any time. Some may be written once, and only while a short window after reset is open. In one register, bits may be set at any time but cleared only once inside the window. Every once-only group has its own lock, which the first accepted write to that group sets.

When the `special_mode` strap is high, all restrictions on the guarded registers are lifted. The one exception is a read-visibility / clock-output control bit. That bit can be written once in every mode, and its reset value follows the strap.

Top module: `cfg_guard_regs`

## Requirements
- R1: Reset values are as follows. Offset 0x24 reads 0x00, 0x35 reads 0x1F, 0x39 reads 0x00 and 0x3D reads 0x00. Offset 0x3C reads 0x10 if `special_mode` was high during reset and 0x00 otherwise. Any other offset reads 0x00.
- R2: The write window covers clock edges 0 to 63, where edge 0 is the first rising edge with `rst_n` high. In normal mode a once-only write on edge 63 is accepted, and the same write on edge 64 or any later edge is ignored.
- R3: At offset 0x24, bits [7:2] take every write. In normal mode, bits [1:0] take only the first write inside the window.
- R4: At offset 0x35 in normal mode, a write can always set bits (new value = old OR data). Only the first write inside the window can clear bits (new value = data).
- R5: At offset 0x39, bits 7, 6 and 3 take every write. In normal mode, bits [5:4] and [2:0] take only the first write inside the window.
- R6: At offset 0x3D in normal mode, only the first write inside the window takes effect. Every other write is ignored.
- R7: The first accepted window write to a once-only group sets that group's lock, even if the data equals the stored value. Each of offsets 0x24, 0x35, 0x39 and 0x3D has its own independent lock.
- R8: With `special_mode` high, offsets 0x24, 0x35, 0x39 and 0x3D store every written byte unchanged, at any time and any number of times.
- R9: At offset 0x3C, every bit except bit 4 is plain read/write storage in both modes.
- R10: Bit 4 of offset 0x3C is the visibility control bit, and `vis_ctl` shows its value. In both modes only the first write to offset 0x3C after reset changes it, and no window applies.
- R11: `rdata` follows `addr` combinationally. A write becomes visible on `rdata` after the clock edge that takes it, and before that edge `rdata` still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| special_mode | input | 1 | Mode strap, 1 lifts the write restrictions |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| vis_ctl | output | 1 | Visibility / clock-output control bit |

## Verification
Two functions can fall in the same cycle. The first is a write landing exactly on the edge where the window closes. The bench provokes it by idling 63 or 64 edges after reset before one map write, and expects that write to be kept in the first case and dropped in the second. The second is a combinational read of the very register being written. The bench samples `rdata` while the write is still pending and expects the old byte, then samples again after the edge and expects the new one.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
    localparam int CFG_DW     = 8;
    localparam int CFG_AW     = 8;
    localparam int CFG_WINDOW = 64;
    localparam int CFG_NG     = 4;
    localparam int VIS_BIT    = 4;

    localparam logic [7:0] OFF_TMASK = 8'h24;
    localparam logic [7:0] OFF_BPROT = 8'h35;
    localparam logic [7:0] OFF_OPT   = 8'h39;
    localparam logic [7:0] OFF_MISC  = 8'h3C;
    localparam logic [7:0] OFF_MAP   = 8'h3D;

    // off: offset, rst: reset value, any: free bits,
    // once: window-once bits, set: bits settable at any time
    typedef struct packed {
        logic [7:0] off;
        logic [7:0] rst;
        logic [7:0] any;
        logic [7:0] once;
        logic [7:0] set;
    } guard_cfg_t;

    // index 0 timer mask, 1 block protect, 2 options, 3 map
    localparam guard_cfg_t GUARD_TAB [CFG_NG] = '{
        '{OFF_TMASK, 8'h00, 8'hFC, 8'h03, 8'h00},
        '{OFF_BPROT, 8'h1F, 8'h00, 8'hFF, 8'hFF},
        '{OFF_OPT,   8'h00, 8'hC8, 8'h37, 8'h00},
        '{OFF_MAP,   8'h00, 8'h00, 8'hFF, 8'h00}
    };
endpackage

// File: rtl/cfg_window_timer.sv
module cfg_window_timer #(
    parameter int WINDOW = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic win_open
);
    localparam int CW = $clog2(WINDOW + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt < CW'(WINDOW)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign win_open = (st_q.cnt < CW'(WINDOW));
endmodule

// File: rtl/cfg_guard_reg.sv
module cfg_guard_reg #(
    parameter int               DW        = 8,
    parameter logic [DW-1:0]    RST_VAL   = '0,
    parameter logic [DW-1:0]    ANY_MASK  = '0,
    parameter logic [DW-1:0]    ONCE_MASK = '0,
    parameter logic [DW-1:0]    SET_MASK  = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          special_mode,
    input  logic          win_open,
    input  logic          wr_hit,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    typedef struct packed {
        logic [DW-1:0] val;
        logic          lock;
    } greg_t;

    greg_t st_d, st_q;
    logic          once_ok;
    logic [DW-1:0] take;

    always_comb begin
        st_d    = st_q;
        once_ok = win_open && !st_q.lock;
        take    = ANY_MASK | (once_ok ? ONCE_MASK : '0);
        if (wr_hit) begin
            if (special_mode) begin
                st_d.val = wdata;
            end else begin
                st_d.val = (st_q.val & ~take) | (wdata & take) | (wdata & SET_MASK);
                if (once_ok && (ONCE_MASK != '0)) begin
                    st_d.lock = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{val: RST_VAL, lock: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.val;
endmodule

// File: rtl/cfg_misc_reg.sv
module cfg_misc_reg #(
    parameter int DW      = 8,
    parameter int VIS_POS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          special_mode,
    input  logic          wr_hit,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    localparam logic [DW-1:0] VIS_MASK = DW'(1) << VIS_POS;

    typedef struct packed {
        logic [DW-1:0] val;
        logic          vis_lock;
    } mreg_t;

    mreg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hit) begin
            st_d.val = (st_q.val & VIS_MASK) | (wdata & ~VIS_MASK);
            if (!st_q.vis_lock) begin
                st_d.val[VIS_POS] = wdata[VIS_POS];
                st_d.vis_lock     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{val: (special_mode ? VIS_MASK : '0), vis_lock: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.val;
endmodule

// File: rtl/cfg_guard_regs.sv
module cfg_guard_regs
    import cfg_guard_pkg::*;
#(
    parameter int DW     = CFG_DW,
    parameter int AW     = CFG_AW,
    parameter int WINDOW = CFG_WINDOW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          special_mode,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          vis_ctl
);
    localparam int NG = CFG_NG;

    logic          win_open;
    logic [DW-1:0] greg_q [NG];
    logic [DW-1:0] misc_q;

    cfg_window_timer #(.WINDOW(WINDOW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_open (win_open)
    );

    for (genvar g = 0; g < NG; g++) begin : g_guard
        cfg_guard_reg #(
            .DW        (DW),
            .RST_VAL   (DW'(GUARD_TAB[g].rst)),
            .ANY_MASK  (DW'(GUARD_TAB[g].any)),
            .ONCE_MASK (DW'(GUARD_TAB[g].once)),
            .SET_MASK  (DW'(GUARD_TAB[g].set))
        ) u_reg (
            .clk          (clk),
            .rst_n        (rst_n),
            .special_mode (special_mode),
            .win_open     (win_open),
            .wr_hit       (wr_en && (addr == AW'(GUARD_TAB[g].off))),
            .wdata        (wdata),
            .q            (greg_q[g])
        );
    end

    cfg_misc_reg #(.DW(DW), .VIS_POS(VIS_BIT)) u_misc (
        .clk          (clk),
        .rst_n        (rst_n),
        .special_mode (special_mode),
        .wr_hit       (wr_en && (addr == AW'(OFF_MISC))),
        .wdata        (wdata),
        .q            (misc_q)
    );

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NG; i++) begin
            if (addr == AW'(GUARD_TAB[i].off)) begin
                rdata = greg_q[i];
            end
        end
        if (addr == AW'(OFF_MISC)) begin
            rdata = misc_q;
        end
    end

    assign vis_ctl = misc_q[VIS_BIT];
endmodule

// File: rtl/cfg_guard_chk.sv
module cfg_guard_chk
    import cfg_guard_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       special_mode,
    input logic       wr_en,
    input logic [7:0] addr,
    input logic       vis_ctl,
    input logic [7:0] tmsk,
    input logic [7:0] bprot,
    input logic [7:0] opt,
    input logic [7:0] map
);
    logic [7:0] cyc_q;
    logic       vis_seen_q;
    logic       closed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q      <= '0;
            vis_seen_q <= 1'b0;
        end else begin
            if (cyc_q < 8'(CFG_WINDOW)) cyc_q <= cyc_q + 1'b1;
            if (wr_en && addr == OFF_MISC) vis_seen_q <= 1'b1;
        end
    end

    assign closed = !special_mode && (cyc_q >= 8'(CFG_WINDOW));

    assert_map_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        closed |=> $stable(map));

    assert_tmsk_low_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        closed |=> $stable(tmsk[1:0]));

    assert_opt_once_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        closed |=> ($stable(opt[5:4]) && $stable(opt[2:0])));

    assert_bprot_no_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        closed |=> ((bprot & $past(bprot)) == $past(bprot)));

    assert_vis_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
        vis_seen_q |=> $stable(vis_ctl));
endmodule

bind cfg_guard_regs cfg_guard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .special_mode (special_mode),
    .wr_en        (wr_en),
    .addr         (addr),
    .vis_ctl      (vis_ctl),
    .tmsk         (greg_q[0]),
    .bprot        (greg_q[1]),
    .opt          (greg_q[2]),
    .map          (greg_q[3])
);

// File: tb/tb_cfg_guard_regs.sv
module tb_cfg_guard_regs;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] d;
        logic [7:0] e;
    } vec_t;

    // normal mode, applied on edges 0..11 after reset
    localparam vec_t VEC [NVEC] = '{
        '{8'h3D, 8'hA5, 8'hA5},
        '{8'h3D, 8'h5A, 8'hA5},
        '{8'h24, 8'h03, 8'h03},
        '{8'h24, 8'hFC, 8'hFF},
        '{8'h24, 8'h00, 8'h03},
        '{8'h35, 8'h00, 8'h00},
        '{8'h35, 8'h1F, 8'h1F},
        '{8'h35, 8'h00, 8'h1F},
        '{8'h39, 8'h39, 8'h39},
        '{8'h39, 8'hC6, 8'hF1},
        '{8'h3C, 8'h10, 8'h10},
        '{8'h3C, 8'h2F, 8'h3F}
    };
    localparam string VTAG [NVEC] = '{"R6", "R7", "R3", "R3", "R3", "R4",
                                      "R4", "R4", "R5", "R5", "R10", "R9"};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       special_mode = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       vis_ctl;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    cfg_guard_regs dut (
        .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .vis_ctl(vis_ctl)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%02h exp=%02h", req, got, exp);
        end
    endtask

    task automatic rd(string req, logic [7:0] a, logic [7:0] exp);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic do_reset(logic s);
        wr_en = 1'b0;
        rst_n = 1'b0;
        special_mode = s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        addr = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog got=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset values, normal mode
        do_reset(1'b0);
        rd("R1", 8'h24, 8'h00);
        rd("R1", 8'h35, 8'h1F);
        rd("R1", 8'h39, 8'h00);
        rd("R1", 8'h3C, 8'h00);
        rd("R1", 8'h3D, 8'h00);
        rd("R1", 8'h10, 8'h00);
        chk("R1", {7'd0, vis_ctl}, 8'h00);

        // table walk inside the window
        do_reset(1'b0);
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i].a, VEC[i].d);
            rd(VTAG[i], VEC[i].a, VEC[i].e);
        end
        chk("R10", {7'd0, vis_ctl}, 8'h01);

        // R7: equal-value write still locks; groups independent
        do_reset(1'b0);
        wr(8'h3D, 8'h00);
        wr(8'h3D, 8'h77);
        rd("R7", 8'h3D, 8'h00);
        wr(8'h24, 8'h02);
        rd("R7", 8'h24, 8'h02);

        // R2 window boundary: edge 63 accepted, edge 64 rejected
        do_reset(1'b0);
        idle(63);
        wr(8'h3D, 8'h11);
        rd("R2", 8'h3D, 8'h11);
        do_reset(1'b0);
        idle(64);
        wr(8'h3D, 8'h11);
        rd("R2", 8'h3D, 8'h00);
        // after the window: free bits only
        wr(8'h24, 8'hFF);
        rd("R3", 8'h24, 8'hFC);
        wr(8'h35, 8'h00);
        rd("R4", 8'h35, 8'h1F);
        wr(8'h35, 8'hE0);
        rd("R4", 8'h35, 8'hFF);
        wr(8'h39, 8'hFF);
        rd("R5", 8'h39, 8'hC8);
        // R10: visibility bit has no window
        wr(8'h3C, 8'h10);
        rd("R10", 8'h3C, 8'h10);

        // R11: read of a pending write shows old value, then new
        do_reset(1'b0);
        addr = 8'h3D;
        wdata = 8'h66;
        wr_en = 1'b1;
        #1;
        chk("R11", rdata, 8'h00);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk("R11", rdata, 8'h66);

        // R8 / R1 / R10 special mode
        do_reset(1'b1);
        rd("R1", 8'h3C, 8'h10);
        chk("R10", {7'd0, vis_ctl}, 8'h01);
        idle(70);
        wr(8'h3D, 8'h12);
        rd("R8", 8'h3D, 8'h12);
        wr(8'h3D, 8'h34);
        rd("R8", 8'h3D, 8'h34);
        wr(8'h35, 8'h00);
        rd("R8", 8'h35, 8'h00);
        wr(8'h24, 8'hA5);
        rd("R8", 8'h24, 8'hA5);
        wr(8'h39, 8'h37);
        rd("R8", 8'h39, 8'h37);
        wr(8'h3C, 8'h00);
        rd("R10", 8'h3C, 8'h00);
        wr(8'h3C, 8'h13);
        rd("R9", 8'h3C, 8'h03);
        chk("R10", {7'd0, vis_ctl}, 8'h00);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule